// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries register writes from a fast bus clock domain into a slow low-power clock domain, typically a 32 kHz timekeeping domain. One write is in flight at a time. The bus side latches the address and data into a holding register, then flips a request toggle that crosses into the slow domain. The slow domain detects the toggle, presents the write for one slow cycle and flips an acknowledge toggle that crosses back. When the acknowledge arrives, the bus side drops its busy indication and raises a completion flag.

Software follows progress through four status flags: busy, ready-for-next, complete and error. Each of the last three can be routed to an interrupt. The interrupt-enable register sits entirely in the bus domain. It takes effect at bus speed, is never forwarded and never raises completion. Reading the status register clears the completion flag. A write that arrives while another is still in flight is dropped and raises the error flag. The error flag is cleared by a status write with bit 7 set, and that write crosses the bridge like any other.

Top module: `wsync_bridge`

## Requirements
- R1: After reset the status register reads busy=0, next=1, complete=0, error=0. The interrupt-enable register reads 0, `irq` is 0 and no slow-domain write is presented.
- R2: A write to any address other than the interrupt-enable address, accepted while idle, produces exactly one single-cycle `lp_wr_valid` pulse in the slow domain. That pulse carries the same address and data.
- R3: On the bus cycle after a write is accepted, status bit 10 (busy) reads 1 and bit 9 (next) reads 0. Bit 9 is always the inverse of bit 10.
- R4: When the acknowledge returns, busy clears and status bit 8 (complete) sets on the same bus cycle.
- R5: A bus read of the status address returns the flags as they were before the read and then clears complete. If an acknowledge completes in that same cycle, complete stays set.
- R6: A write to the interrupt-enable address loads bits 9..7 of the write data on the next bus cycle, even while busy. It is never forwarded and leaves busy and complete unchanged.
- R7: A write to any other address issued while busy is dropped, and it sets status bit 7 (error).
- R8: A status write whose data bit 7 is 1 crosses the bridge, and error clears when it completes. A status write with data bit 7 equal to 0 leaves error unchanged.
- R9: `irq` is high exactly when some flag is enabled and set. Enable bit 9 is paired with next, bit 8 with complete and bit 7 with error.
- R10: `bus_rdata` follows `bus_addr` combinationally. The status address returns the flags at bits 10..7, the enable address returns the enables at bits 9..7, and every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| lp_clk | input | 1 | Slow low-power clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_rd | input | 1 | Bus read strobe, one cycle per read |
| bus_addr | input | AW | Bus register address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Read data for the addressed local register |
| irq | output | 1 | Interrupt, OR of enabled status events |
| lp_wr_valid | output | 1 | Single-cycle write strobe in the slow domain |
| lp_wr_addr | output | AW | Address of the forwarded write |
| lp_wr_data | output | DW | Data of the forwarded write |

## Verification
The bench builds the bridge with three synchronizer stages and a 32-bit data path. This makes the status bits 10..7 real and lengthens the round trip enough that a second write can land inside the busy window. The slow clock runs at a 46 ns period, which has no integer relation to the bus clock. The phase between the domains therefore drifts, so random writes see a spread of handshake latencies. A 4-bit address with status at 5 and enables at 6 lets random traffic hit the status address and unmapped offsets as well as ordinary forwarded registers.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  // Status/enable bit positions; software decodes these.
  localparam int ST_BUSY = 10;
  localparam int ST_NEXT = 9;
  localparam int ST_CPL  = 8;
  localparam int ST_ERR  = 7;

  typedef struct packed {
    logic nxt;
    logic cpl;
    logic err;
  } evt_t;
endpackage

// File: rtl/wsync_bit_sync.sv
module wsync_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wsync_bus_ctrl.sv
module wsync_bus_ctrl
  import wsync_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 32,
  parameter int STAT_ADDR = 5,
  parameter int IEN_ADDR  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_lvl,
  output logic          req_tgl,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          busy,
  output logic          cpl,
  output logic          err,
  output logic          ack_edge,
  output evt_t          ien
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
  localparam logic [AW-1:0] IEN_A  = AW'(IEN_ADDR);

  logic busy_q, busy_d;
  logic cpl_q, cpl_d;
  logic err_q, err_d;
  logic req_q, req_d;
  logic ack_prev_q;
  evt_t ien_q, ien_d;
  logic ien_en, hold_en;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;

  logic is_ien, is_stat, accept, collide, err_clr, edge_w;
  evt_t flags;

  // Next-state logic
  always_comb begin
    is_ien  = (addr == IEN_A);
    is_stat = (addr == STAT_A);
    edge_w  = ack_lvl ^ ack_prev_q;
    accept  = wr && !is_ien && !busy_q;
    collide = wr && !is_ien && busy_q;
    err_clr = edge_w && (hold_addr_q == STAT_A) && hold_data_q[ST_ERR];

    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (edge_w) busy_d = 1'b0;

    // completion wins over a clearing read in the same cycle
    cpl_d = cpl_q;
    if (edge_w)              cpl_d = 1'b1;
    else if (rd && is_stat)  cpl_d = 1'b0;

    // a fresh collision wins over a clearing acknowledge
    err_d = err_q;
    if (collide)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;

    req_d   = req_q ^ accept;
    hold_en = accept;
    ien_en  = wr && is_ien;
    ien_d   = evt_t'(wdata[ST_NEXT:ST_ERR]);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cpl_q      <= 1'b0;
      err_q      <= 1'b0;
      req_q      <= 1'b0;
      ack_prev_q <= 1'b0;
      ien_q      <= '0;
    end else begin
      busy_q     <= busy_d;
      cpl_q      <= cpl_d;
      err_q      <= err_d;
      req_q      <= req_d;
      ack_prev_q <= ack_lvl;
      if (ien_en) ien_q <= ien_d;
    end
  end

  // Holding register: stable while busy, sampled by the slow domain
  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_addr_q <= addr;
      hold_data_q <= wdata;
    end
  end

  // Read mux and interrupt
  always_comb begin
    rdata = '0;
    if (is_stat) begin
      rdata[ST_BUSY] = busy_q;
      rdata[ST_NEXT] = !busy_q;
      rdata[ST_CPL]  = cpl_q;
      rdata[ST_ERR]  = err_q;
    end else if (is_ien) begin
      rdata[ST_NEXT:ST_ERR] = ien_q;
    end
    flags.nxt = !busy_q;
    flags.cpl = cpl_q;
    flags.err = err_q;
    irq = |(ien_q & flags);
  end

  assign req_tgl   = req_q;
  assign hold_addr = hold_addr_q;
  assign hold_data = hold_data_q;
  assign busy      = busy_q;
  assign cpl       = cpl_q;
  assign err       = err_q;
  assign ack_edge  = edge_w;
  assign ien       = ien_q;
endmodule

// File: rtl/wsync_lp_side.sv
module wsync_lp_side #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_lvl,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ack_tgl
);
  logic req_prev_q;
  logic valid_q, valid_d;
  logic ack_q, ack_d;
  logic cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    cap_en  = req_lvl ^ req_prev_q;
    valid_d = cap_en;
    ack_d   = ack_q ^ cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      valid_q    <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      req_prev_q <= req_lvl;
      valid_q    <= valid_d;
      ack_q      <= ack_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= hold_addr;
      data_q <= hold_data;
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign ack_tgl  = ack_q;
endmodule

// File: rtl/wsync_bridge.sv
module wsync_bridge
  import wsync_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 32,
  parameter int STAT_ADDR   = 5,
  parameter int IEN_ADDR    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          lp_clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          lp_wr_valid,
  output logic [AW-1:0] lp_wr_addr,
  output logic [DW-1:0] lp_wr_data
);
  logic bus_rstn, lp_rstn;
  logic req_tgl, req_lvl, ack_tgl, ack_lvl;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic busy_w, cpl_w, err_w, ack_edge_w;
  evt_t ien_w;

  wsync_bit_sync #(.STAGES(2)) u_bus_rst (
    .clk(bus_clk), .rst_n(rst_n), .d(1'b1), .q(bus_rstn));
  wsync_bit_sync #(.STAGES(2)) u_lp_rst (
    .clk(lp_clk), .rst_n(rst_n), .d(1'b1), .q(lp_rstn));

  wsync_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(lp_clk), .rst_n(lp_rstn), .d(req_tgl), .q(req_lvl));
  wsync_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rstn), .d(ack_tgl), .q(ack_lvl));

  wsync_bus_ctrl #(
    .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
  ) u_bus (
    .clk(bus_clk), .rst_n(bus_rstn), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .ack_lvl(ack_lvl),
    .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
    .rdata(bus_rdata), .irq(irq), .busy(busy_w), .cpl(cpl_w),
    .err(err_w), .ack_edge(ack_edge_w), .ien(ien_w)
  );

  wsync_lp_side #(.AW(AW), .DW(DW)) u_lp (
    .clk(lp_clk), .rst_n(lp_rstn), .req_lvl(req_lvl),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .wr_valid(lp_wr_valid), .wr_addr(lp_wr_addr), .wr_data(lp_wr_data),
    .ack_tgl(ack_tgl)
  );
endmodule

// File: rtl/wsync_bridge_chk.sv
module wsync_bridge_chk #(
  parameter int AW        = 4,
  parameter int STAT_ADDR = 5,
  parameter int IEN_ADDR  = 6
) (
  input logic          bus_clk,
  input logic          lp_clk,
  input logic          bus_rstn,
  input logic          lp_rstn,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic          busy,
  input logic          cpl,
  input logic          err,
  input logic          ack_edge,
  input logic [2:0]    ien,
  input logic          irq,
  input logic          lp_wr_valid
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
  localparam logic [AW-1:0] IEN_A  = AW'(IEN_ADDR);

  assert_lp_pulse_R2: assert property (@(posedge lp_clk) disable iff (!lp_rstn)
    lp_wr_valid |=> !lp_wr_valid);

  assert_accept_busy_R3: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    (bus_wr && bus_addr != IEN_A && !busy) |=> busy);

  assert_ack_done_R4: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    ack_edge |=> (cpl && !busy));

  assert_fall_cpl_R4: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    $fell(busy) |-> cpl);

  assert_rd_clear_R5: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    (bus_rd && bus_addr == STAT_A && !ack_edge) |=> !cpl);

  assert_ien_bypass_R6: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    (bus_wr && bus_addr == IEN_A && !busy) |=> !busy);

  assert_collide_err_R7: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    (bus_wr && bus_addr != IEN_A && busy) |=> err);

  assert_irq_needs_en_R9: assert property (@(posedge bus_clk) disable iff (!bus_rstn)
    irq |-> (ien != 3'b000));
endmodule

bind wsync_bridge wsync_bridge_chk #(
  .AW(AW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
) u_chk (
  .bus_clk(bus_clk), .lp_clk(lp_clk), .bus_rstn(bus_rstn), .lp_rstn(lp_rstn),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .busy(busy_w), .cpl(cpl_w), .err(err_w), .ack_edge(ack_edge_w),
  .ien(ien_w), .irq(irq), .lp_wr_valid(lp_wr_valid)
);

// File: tb/wsync_bridge_tb.sv
module wsync_bridge_tb;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int STAT = 5;
  localparam int IEN = 6;

  logic bus_clk = 1'b0, lp_clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq, lp_wr_valid;
  logic [AW-1:0] lp_wr_addr;
  logic [DW-1:0] lp_wr_data;

  int n_run = 0, n_fail = 0;
  int lp_cnt = 0;
  logic [AW-1:0] lp_last_addr = '0;
  logic [DW-1:0] lp_last_data = '0;

  always #5  bus_clk = ~bus_clk;
  always #23 lp_clk  = ~lp_clk;

  wsync_bridge #(.AW(AW), .DW(DW), .STAT_ADDR(STAT), .IEN_ADDR(IEN),
                 .SYNC_STAGES(3)) u_dut (
    .bus_clk(bus_clk), .lp_clk(lp_clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .lp_wr_valid(lp_wr_valid), .lp_wr_addr(lp_wr_addr), .lp_wr_data(lp_wr_data));

  always @(negedge lp_clk) begin
    if (lp_wr_valid) begin
      lp_cnt++;
      lp_last_addr = lp_wr_addr;
      lp_last_data = lp_wr_data;
    end
  end

  function automatic logic [DW-1:0] exp_stat(input logic b, input logic c, input logic e);
    logic [DW-1:0] v = '0;
    v[10] = b; v[9] = !b; v[8] = c; v[7] = e;
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge bus_clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge bus_clk); #1;
    bus_wr = 1'b0; bus_addr = AW'(STAT);
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    @(posedge bus_clk); #1;
    bus_rd = 1'b1; bus_addr = AW'(STAT);
    @(negedge bus_clk); v = bus_rdata;
    @(posedge bus_clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a;
    @(negedge bus_clk); v = bus_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [DW-1:0] v;
    cyc = 0;
    bus_addr = AW'(STAT);
    do begin
      @(negedge bus_clk); v = bus_rdata; cyc++;
    end while (v[10] && cyc < 200);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int cyc, c0;
    logic exp_err;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(posedge bus_clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge lp_clk);
    @(posedge bus_clk); #1;

    // R1 reset state
    peek(AW'(STAT), v); check("R1 status", v, exp_stat(0, 0, 0));
    peek(AW'(IEN), v);  check("R1 ien", v, '0);
    check("R1 irq", {31'b0, irq}, '0);
    check("R1 lp writes", lp_cnt, 0);

    // R2/R3/R4 single write
    c0 = lp_cnt;
    do_write(4'd1, 32'hCAFE_0001);
    peek(AW'(STAT), v); check("R3 busy after accept", v, exp_stat(1, 0, 0));
    wait_idle(cyc);
    peek(AW'(STAT), v); check("R4 cpl with idle", v, exp_stat(0, 1, 0));
    check("R2 one lp write", lp_cnt, c0 + 1);
    check("R2 lp addr", {28'b0, lp_last_addr}, 32'd1);
    check("R2 lp data", lp_last_data, 32'hCAFE_0001);

    // R5 read returns old value then clears
    do_read(v); check("R5 read value", v, exp_stat(0, 1, 0));
    peek(AW'(STAT), v); check("R5 cleared", v, exp_stat(0, 0, 0));

    // R10 unmapped address
    peek(4'd3, v); check("R10 unmapped", v, '0);

    // R6 enable write during busy
    c0 = lp_cnt;
    do_write(4'd2, 32'h1111_2222);
    do_write(AW'(IEN), 32'h0000_0380);
    peek(AW'(IEN), v); check("R6 ien loaded", v, 32'h0000_0380);
    peek(AW'(STAT), v); check("R6 busy kept, no err", v, exp_stat(1, 0, 0));
    wait_idle(cyc);
    check("R6 not forwarded", lp_cnt, c0 + 1);
    do_write(AW'(IEN), 32'h0);
    do_read(v);

    // R7 collision
    c0 = lp_cnt;
    do_write(4'd4, 32'hAAAA_0004);
    do_write(4'd7, 32'hBBBB_0007);
    peek(AW'(STAT), v); check("R7 err set", v, exp_stat(1, 0, 1));
    wait_idle(cyc);
    check("R7 dropped count", lp_cnt, c0 + 1);
    check("R7 first kept", lp_last_data, 32'hAAAA_0004);

    // R9 interrupt routing
    do_write(AW'(IEN), 32'h0000_0080);
    @(negedge bus_clk); check("R9 err irq", {31'b0, irq}, 32'd1);
    do_write(AW'(IEN), 32'h0000_0000);
    @(negedge bus_clk); check("R9 masked", {31'b0, irq}, 32'd0);
    do_write(AW'(IEN), 32'h0000_0200);
    @(negedge bus_clk); check("R9 next irq", {31'b0, irq}, 32'd1);
    do_write(AW'(IEN), 32'h0000_0000);

    // R8 clearing error through the bridge
    do_read(v);
    do_write(AW'(STAT), 32'h0);
    wait_idle(cyc);
    peek(AW'(STAT), v); check("R8 bit7=0 keeps err", v, exp_stat(0, 1, 1));
    c0 = lp_cnt;
    do_write(AW'(STAT), 32'h0000_0080);
    wait_idle(cyc);
    peek(AW'(STAT), v); check("R8 err cleared", v, exp_stat(0, 1, 0));
    check("R8 forwarded", lp_cnt, c0 + 1);
    check("R8 lp addr", {28'b0, lp_last_addr}, STAT);
    do_read(v);

    // Random traffic: R2, R4, R5, R8
    exp_err = 1'b0;
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom_range(0, 15));
      if (a == AW'(IEN)) a = 4'd0;
      d = $urandom;
      if (a == AW'(STAT) && d[7]) exp_err = 1'b0;
      c0 = lp_cnt;
      do_write(a, d);
      wait_idle(cyc);
      check("R2 rand count", lp_cnt, c0 + 1);
      check("R2 rand data", lp_last_data, d);
      check("R2 rand addr", {28'b0, lp_last_addr}, {28'b0, a});
      do_read(v);
      check("R5 rand status", v, exp_stat(0, 1, exp_err));
      if ((i % 7) == 3) begin
        do_write(4'd9, 32'h1);
        do_write(4'd9, 32'h2);
        exp_err = 1'b1;
        wait_idle(cyc);
        do_read(v);
        check("R7 rand collide", v, exp_stat(0, 1, 1));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule